// File: doc/BRIEF.md
# Logical-Shift-Left Decode and Execute Unit

This unit takes one instruction word of a compact 16/32-bit instruction set, together with the operand values already read from the register file. It recognises the four logical-shift-left encodings: an immediate amount and a register amount, each in a narrow (16-bit) and a wide (32-bit) layout. For a match it produces the shifted result, the register indices, and the new N, Z and C flags. Each output has a write enable. Encodings that belong to a register move, encodings with an unpredictable register choice, and words that match none of the four patterns are reported on separate flags. Those cases write nothing.

The unit is driven by a single strobe. Two states sequence it. In ST_IDLE nothing is presented. A strobe moves it to ST_EMIT (IDLE->EMIT), where the registered outcome is shown for one cycle. Another strobe keeps it in ST_EMIT (EMIT->EMIT). No strobe returns it to ST_IDLE (EMIT->IDLE), and ST_IDLE with no strobe stays put (IDLE->IDLE). The shifter extends the source with the incoming carry, so one datapath covers every count from 0 to 255.

Top module: `lsl_exec`

## Requirements
- R1: Narrow immediate form: with is_wide=0 and instr[15:11]=00000, the amount is instr[10:6], the source index rs_idx is {0,instr[5:3]}, the destination rd_idx is {0,instr[2:0]}, and result is src_val shifted left by the amount, with reg_we=1.
- R2: In either immediate form, an amount of zero raises other_insn and gives reg_we=0 and flag_we=0.
- R3: Both narrow forms give flag_we=1 only when in_cond_blk=0, and flag_we=0 when in_cond_blk=1. in_cond_blk has no effect on the wide forms.
- R4: Wide immediate form: is_wide=1, instr[31:21]=11101010010, instr[19:16]=1111, instr[15]=0, instr[5:4]=00. The amount is {instr[14:12],instr[7:6]}, rd_idx is instr[11:8], rs_idx is instr[3:0], and flag_we equals instr[20].
- R5: Narrow register form: instr[15:6]=0100000010. ra_idx is {0,instr[5:3]}, rd_idx and rs_idx are both {0,instr[2:0]}, and the count is amt_val.
- R6: Wide register form: instr[31:21]=11111010000, instr[15:12]=1111, instr[7:4]=0000. rs_idx is instr[19:16], rd_idx is instr[11:8], ra_idx is instr[3:0], and flag_we equals instr[20].
- R7: In a wide form, any of its register fields equal to 13 or 15 raises unpredictable with reg_we=0 and flag_we=0. For the immediate form the zero-amount rule of R2 takes precedence.
- R8: The register-form count is the 8-bit unsigned amt_val (the low byte of the amount register), so counts 0 to 255 apply.
- R9: When flags are written, flag_n is result bit 31, flag_z is 1 exactly when result is zero, and flag_c is the last bit shifted out.
- R10: A count of zero returns src_val unchanged with flag_c equal to carry_in.
- R11: A count of 32 gives result 0 with flag_c equal to src_val bit 0. A count above 32 gives result 0 with flag_c 0.
- R12: Outputs appear on the cycle after a strobe, with out_valid=1 for that cycle only. reg_we and flag_we are 0 whenever out_valid is 0. Reset clears out_valid, reg_we and flag_we.
- R13: A word matching none of the four patterns raises no_match with reg_we=0 and flag_we=0. At most one of reg_we, other_insn, unpredictable and no_match is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: instruction and operands are present |
| instr | input | 32 | Instruction word; a narrow word sits in bits 15:0 |
| is_wide | input | 1 | 1 for a 32-bit encoding |
| in_cond_blk | input | 1 | Core is inside a conditional-execution block |
| src_val | input | DATA_W | Value to be shifted |
| amt_val | input | CNT_W | Low byte of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered outcome is present |
| rd_idx | output | 4 | Destination register index |
| rs_idx | output | 4 | Index of the register being shifted |
| ra_idx | output | 4 | Index of the amount register (register forms) |
| reg_we | output | 1 | Write the result to rd_idx |
| result | output | DATA_W | Shifted value |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| flag_we | output | 1 | Write N, Z and C |
| other_insn | output | 1 | Encoding belongs to a register move |
| unpredictable | output | 1 | Wide form names the stack pointer or program counter |
| no_match | output | 1 | Word matches none of the four patterns |

## Verification
The bench builds the unit with its defaults, DATA_W=32 and CNT_W=8, so the amount input covers the whole 0 to 255 range. This makes reachable the boundary at exactly 32 (carry from bit 0), the first count past it (33), and the top count 255. At 255 the upper count bits force the result to zero. With the 33-bit carry-extended shifter at these widths, the six barrel stages and the out-of-range clamp are both exercised, together with every decode outcome of the four layouts.

// File: rtl/lsl_pkg.sv
package lsl_pkg;

    localparam int INSN_W = 32;
    localparam int IDX_W  = 4;
    localparam int IMM_W  = 5;

    typedef enum logic [2:0] {
        FM_NONE,
        FM_IMM_N,
        FM_IMM_W,
        FM_REG_N,
        FM_REG_W
    } form_e;

    typedef enum logic [1:0] {
        OC_EXEC,
        OC_OTHER,
        OC_UNPRED,
        OC_NOMATCH
    } outcome_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_EMIT
    } state_e;

    typedef struct packed {
        form_e              form;
        outcome_e           outcome;
        logic [IDX_W-1:0]   rd;
        logic [IDX_W-1:0]   rs;
        logic [IDX_W-1:0]   ra;
        logic [IMM_W-1:0]   imm_amt;
        logic               set_flags;
    } dec_t;

endpackage

// File: rtl/lsl_decode.sv
module lsl_decode
    import lsl_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    input  logic              is_wide,
    input  logic              in_cond_blk,
    output dec_t              dec
);

    function automatic logic reserved_reg(input logic [IDX_W-1:0] r);
        return (r == 4'd13) || (r == 4'd15);
    endfunction

    logic hit_imm_n;
    logic hit_reg_n;
    logic hit_imm_w;
    logic hit_reg_w;

    always_comb begin
        hit_imm_n = !is_wide && (instr[15:11] == 5'b00000);
        hit_reg_n = !is_wide && (instr[15:6] == 10'b0100000010);
        hit_imm_w = is_wide && (instr[31:21] == 11'b11101010010)
                    && (instr[19:16] == 4'b1111) && !instr[15]
                    && (instr[5:4] == 2'b00);
        hit_reg_w = is_wide && (instr[31:21] == 11'b11111010000)
                    && (instr[15:12] == 4'b1111)
                    && (instr[7:4] == 4'b0000);
    end

    always_comb begin
        dec         = '0;
        dec.form    = FM_NONE;
        dec.outcome = OC_NOMATCH;
        if (hit_imm_n) begin
            dec.form      = FM_IMM_N;
            dec.rd        = {1'b0, instr[2:0]};
            dec.rs        = {1'b0, instr[5:3]};
            dec.imm_amt   = instr[10:6];
            dec.set_flags = !in_cond_blk;
            dec.outcome   = (instr[10:6] == '0) ? OC_OTHER : OC_EXEC;
        end else if (hit_reg_n) begin
            dec.form      = FM_REG_N;
            dec.rd        = {1'b0, instr[2:0]};
            dec.rs        = {1'b0, instr[2:0]};
            dec.ra        = {1'b0, instr[5:3]};
            dec.set_flags = !in_cond_blk;
            dec.outcome   = OC_EXEC;
        end else if (hit_imm_w) begin
            dec.form      = FM_IMM_W;
            dec.rd        = instr[11:8];
            dec.rs        = instr[3:0];
            dec.imm_amt   = {instr[14:12], instr[7:6]};
            dec.set_flags = instr[20];
            if ({instr[14:12], instr[7:6]} == '0) begin
                dec.outcome = OC_OTHER;
            end else if (reserved_reg(instr[11:8]) || reserved_reg(instr[3:0])) begin
                dec.outcome = OC_UNPRED;
            end else begin
                dec.outcome = OC_EXEC;
            end
        end else if (hit_reg_w) begin
            dec.form      = FM_REG_W;
            dec.rd        = instr[11:8];
            dec.rs        = instr[19:16];
            dec.ra        = instr[3:0];
            dec.set_flags = instr[20];
            if (reserved_reg(instr[11:8]) || reserved_reg(instr[19:16])
                || reserved_reg(instr[3:0])) begin
                dec.outcome = OC_UNPRED;
            end else begin
                dec.outcome = OC_EXEC;
            end
        end
    end

endmodule

// File: rtl/lsl_shift.sv
module lsl_shift #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    localparam int EXT_W = DATA_W + 1;
    localparam int STG   = $clog2(EXT_W);

    logic [EXT_W-1:0] stg [0:STG];
    logic             big;

    assign stg[0] = {cin, src};

    for (genvar s = 0; s < STG; s++) begin : g_stage
        assign stg[s+1] = cnt[s] ? (stg[s] << (1 << s)) : stg[s];
    end

    if (CNT_W > STG) begin : g_clamp
        assign big = |cnt[CNT_W-1:STG];
    end else begin : g_noclamp
        assign big = 1'b0;
    end

    assign {cout, res} = big ? '0 : stg[STG];

endmodule

// File: rtl/lsl_flags.sv
module lsl_flags #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    output logic              neg,
    output logic              zero
);

    assign neg  = res[DATA_W-1];
    assign zero = (res == '0);

endmodule

// File: rtl/lsl_exec.sv
module lsl_exec
    import lsl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic              is_wide,
    input  logic              in_cond_blk,
    input  logic [DATA_W-1:0] src_val,
    input  logic [CNT_W-1:0]  amt_val,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [3:0]        rd_idx,
    output logic [3:0]        rs_idx,
    output logic [3:0]        ra_idx,
    output logic              reg_we,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_we,
    output logic              other_insn,
    output logic              unpredictable,
    output logic              no_match
);

    dec_t              dec;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic              f_n;
    logic              f_z;
    logic              do_exec;
    state_e            state_q;
    state_e            state_d;

    lsl_decode u_decode (
        .instr       (instr),
        .is_wide     (is_wide),
        .in_cond_blk (in_cond_blk),
        .dec         (dec)
    );

    always_comb begin
        if (dec.form == FM_IMM_N || dec.form == FM_IMM_W) begin
            cnt = {{(CNT_W-IMM_W){1'b0}}, dec.imm_amt};
        end else begin
            cnt = amt_val;
        end
    end

    lsl_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .src  (src_val),
        .cnt  (cnt),
        .cin  (carry_in),
        .res  (sh_res),
        .cout (sh_c)
    );

    lsl_flags #(.DATA_W(DATA_W)) u_flags (
        .res  (sh_res),
        .neg  (f_n),
        .zero (f_z)
    );

    assign do_exec = (dec.outcome == OC_EXEC);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_idx        <= '0;
            rs_idx        <= '0;
            ra_idx        <= '0;
            result        <= '0;
            flag_n        <= 1'b0;
            flag_z        <= 1'b0;
            flag_c        <= 1'b0;
            reg_we        <= 1'b0;
            flag_we       <= 1'b0;
            other_insn    <= 1'b0;
            unpredictable <= 1'b0;
            no_match      <= 1'b0;
        end else if (in_valid) begin
            rd_idx        <= dec.rd;
            rs_idx        <= dec.rs;
            ra_idx        <= dec.ra;
            result        <= sh_res;
            flag_n        <= f_n;
            flag_z        <= f_z;
            flag_c        <= sh_c;
            reg_we        <= do_exec;
            flag_we       <= do_exec && dec.set_flags;
            other_insn    <= (dec.outcome == OC_OTHER);
            unpredictable <= (dec.outcome == OC_UNPRED);
            no_match      <= (dec.outcome == OC_NOMATCH);
        end else begin
            reg_we        <= 1'b0;
            flag_we       <= 1'b0;
            other_insn    <= 1'b0;
            unpredictable <= 1'b0;
            no_match      <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/lsl_exec_chk.sv
module lsl_exec_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              is_wide,
    input logic              in_cond_blk,
    input logic              out_valid,
    input logic              reg_we,
    input logic              flag_we,
    input logic [DATA_W-1:0] result,
    input logic              flag_n,
    input logic              flag_z,
    input logic              other_insn,
    input logic              unpredictable,
    input logic              no_match
);

    a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!reg_we && !flag_we));

    a_r2_other_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        other_insn |-> (!reg_we && !flag_we));

    a_r7_unpred_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        unpredictable |-> (!reg_we && !flag_we));

    a_r13_nomatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> (!reg_we && !flag_we));

    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, other_insn, unpredictable, no_match}));

    a_r9_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flag_n == result[DATA_W-1]));

    a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flag_z == (result == '0)));

    a_r3_narrow_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_wide && in_cond_blk) |=> !flag_we);

endmodule

bind lsl_exec lsl_exec_chk #(.DATA_W(DATA_W)) u_lsl_exec_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .is_wide       (is_wide),
    .in_cond_blk   (in_cond_blk),
    .out_valid     (out_valid),
    .reg_we        (reg_we),
    .flag_we       (flag_we),
    .result        (result),
    .flag_n        (flag_n),
    .flag_z        (flag_z),
    .other_insn    (other_insn),
    .unpredictable (unpredictable),
    .no_match      (no_match)
);

// File: tb/test_lsl_exec.sv
module test_lsl_exec;

    localparam logic [1:0] K_EXE = 2'd0;
    localparam logic [1:0] K_OTH = 2'd1;
    localparam logic [1:0] K_UNP = 2'd2;
    localparam logic [1:0] K_NOM = 2'd3;

    typedef struct packed {
        logic [31:0] instr;
        logic        wide;
        logic        cb;
        logic [31:0] src;
        logic [7:0]  amt;
        logic        cin;
        logic [1:0]  kind;
        logic        isreg;
        logic [3:0]  rd;
        logic [3:0]  rs;
        logic [3:0]  ra;
        logic [31:0] res;
        logic        c;
        logic        fwe;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        // R1 narrow immediate by 4
        '{32'h0000_0111, 1'b0, 1'b0, 32'h0000_00F1, 8'h00, 1'b0, K_EXE, 1'b0, 4'd1, 4'd2, 4'd0, 32'h0000_0F10, 1'b0, 1'b1, 4'd1},
        // R3 same inside conditional block: no flag write
        '{32'h0000_0111, 1'b0, 1'b1, 32'h0000_00F1, 8'h00, 1'b0, K_EXE, 1'b0, 4'd1, 4'd2, 4'd0, 32'h0000_0F10, 1'b0, 1'b0, 4'd3},
        // R1 by 1, carry from bit 31
        '{32'h0000_005F, 1'b0, 1'b0, 32'h8000_0001, 8'h00, 1'b0, K_EXE, 1'b0, 4'd7, 4'd3, 4'd0, 32'h0000_0002, 1'b1, 1'b1, 4'd1},
        // R9 by 31, negative result
        '{32'h0000_07C0, 1'b0, 1'b0, 32'h0000_0003, 8'h00, 1'b0, K_EXE, 1'b0, 4'd0, 4'd0, 4'd0, 32'h8000_0000, 1'b1, 1'b1, 4'd9},
        // R2 narrow zero amount
        '{32'h0000_0011, 1'b0, 1'b0, 32'h0000_0001, 8'h00, 1'b0, K_OTH, 1'b0, 4'd0, 4'd0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd2},
        // R5 narrow register by 8
        '{32'h0000_408C, 1'b0, 1'b0, 32'h0000_0001, 8'h08, 1'b0, K_EXE, 1'b1, 4'd4, 4'd4, 4'd1, 32'h0000_0100, 1'b0, 1'b1, 4'd5},
        // R10 count zero, carry in 1
        '{32'h0000_408C, 1'b0, 1'b0, 32'h8000_0000, 8'h00, 1'b1, K_EXE, 1'b1, 4'd4, 4'd4, 4'd1, 32'h8000_0000, 1'b1, 1'b1, 4'd10},
        // R10 count zero, carry in 0
        '{32'h0000_408C, 1'b0, 1'b0, 32'h0000_0005, 8'h00, 1'b0, K_EXE, 1'b1, 4'd4, 4'd4, 4'd1, 32'h0000_0005, 1'b0, 1'b1, 4'd10},
        // R11 count 32
        '{32'h0000_408C, 1'b0, 1'b0, 32'h0000_0001, 8'h20, 1'b0, K_EXE, 1'b1, 4'd4, 4'd4, 4'd1, 32'h0000_0000, 1'b1, 1'b1, 4'd11},
        // R11 count 33
        '{32'h0000_408C, 1'b0, 1'b0, 32'hFFFF_FFFF, 8'h21, 1'b1, K_EXE, 1'b1, 4'd4, 4'd4, 4'd1, 32'h0000_0000, 1'b0, 1'b1, 4'd11},
        // R8 count 255
        '{32'h0000_408C, 1'b0, 1'b0, 32'hFFFF_FFFF, 8'hFF, 1'b1, K_EXE, 1'b1, 4'd4, 4'd4, 4'd1, 32'h0000_0000, 1'b0, 1'b1, 4'd8},
        // R8 count 64 (only the clamp bits set)
        '{32'h0000_408C, 1'b0, 1'b0, 32'hFFFF_FFFF, 8'h40, 1'b1, K_EXE, 1'b1, 4'd4, 4'd4, 4'd1, 32'h0000_0000, 1'b0, 1'b1, 4'd8},
        // R8 count 31
        '{32'h0000_408C, 1'b0, 1'b0, 32'h0000_0003, 8'h1F, 1'b0, K_EXE, 1'b1, 4'd4, 4'd4, 4'd1, 32'h8000_0000, 1'b1, 1'b1, 4'd8},
        // R3 narrow register inside block
        '{32'h0000_408C, 1'b0, 1'b1, 32'hC000_0000, 8'h01, 1'b0, K_EXE, 1'b1, 4'd4, 4'd4, 4'd1, 32'h8000_0000, 1'b1, 1'b0, 4'd3},
        // R4 wide immediate by 5, S=1
        '{32'hEA5F_1243, 1'b1, 1'b0, 32'h0000_0007, 8'h00, 1'b0, K_EXE, 1'b0, 4'd2, 4'd3, 4'd0, 32'h0000_00E0, 1'b0, 1'b1, 4'd4},
        // R4 wide immediate S=0
        '{32'hEA4F_1243, 1'b1, 1'b0, 32'h0000_0007, 8'h00, 1'b0, K_EXE, 1'b0, 4'd2, 4'd3, 4'd0, 32'h0000_00E0, 1'b0, 1'b0, 4'd4},
        // R3 wide form ignores the block bit
        '{32'hEA5F_1243, 1'b1, 1'b1, 32'h0000_0007, 8'h00, 1'b0, K_EXE, 1'b0, 4'd2, 4'd3, 4'd0, 32'h0000_00E0, 1'b0, 1'b1, 4'd3},
        // R4 wide immediate by 31
        '{32'hEA5F_70C1, 1'b1, 1'b0, 32'h0000_0001, 8'h00, 1'b1, K_EXE, 1'b0, 4'd0, 4'd1, 4'd0, 32'h8000_0000, 1'b0, 1'b1, 4'd4},
        // R2 wide zero amount
        '{32'hEA5F_0203, 1'b1, 1'b0, 32'h0000_0001, 8'h00, 1'b0, K_OTH, 1'b0, 4'd0, 4'd0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd2},
        // R7 wide immediate Rd=13
        '{32'hEA5F_1D43, 1'b1, 1'b0, 32'h0000_0001, 8'h00, 1'b0, K_UNP, 1'b0, 4'd0, 4'd0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd7},
        // R7 wide immediate Rm=15
        '{32'hEA5F_124F, 1'b1, 1'b0, 32'h0000_0001, 8'h00, 1'b0, K_UNP, 1'b0, 4'd0, 4'd0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd7},
        // R6 wide register by 4
        '{32'hFA11_F203, 1'b1, 1'b0, 32'h1234_5678, 8'h04, 1'b0, K_EXE, 1'b1, 4'd2, 4'd1, 4'd3, 32'h2345_6780, 1'b1, 1'b1, 4'd6},
        // R6 wide register S=0
        '{32'hFA01_F203, 1'b1, 1'b0, 32'h1234_5678, 8'h04, 1'b0, K_EXE, 1'b1, 4'd2, 4'd1, 4'd3, 32'h2345_6780, 1'b1, 1'b0, 4'd6},
        // R11 wide register count 32
        '{32'hFA11_F203, 1'b1, 1'b0, 32'h8000_0001, 8'h20, 1'b0, K_EXE, 1'b1, 4'd2, 4'd1, 4'd3, 32'h0000_0000, 1'b1, 1'b1, 4'd11},
        // R7 wide register Rn=13, Rm=13, Rd=15
        '{32'hFA1D_F203, 1'b1, 1'b0, 32'h0000_0001, 8'h01, 1'b0, K_UNP, 1'b1, 4'd0, 4'd0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd7},
        '{32'hFA11_F20D, 1'b1, 1'b0, 32'h0000_0001, 8'h01, 1'b0, K_UNP, 1'b1, 4'd0, 4'd0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd7},
        '{32'hFA11_FF03, 1'b1, 1'b0, 32'h0000_0001, 8'h01, 1'b0, K_UNP, 1'b1, 4'd0, 4'd0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd7},
        // R13 narrow and wide mismatches
        '{32'h0000_4180, 1'b0, 1'b0, 32'h0000_0001, 8'h01, 1'b0, K_NOM, 1'b0, 4'd0, 4'd0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd13},
        '{32'hEA5F_9243, 1'b1, 1'b0, 32'h0000_0001, 8'h01, 1'b0, K_NOM, 1'b0, 4'd0, 4'd0, 4'd0, 32'h0, 1'b0, 1'b0, 4'd13}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        is_wide = 1'b0;
    logic        in_cond_blk = 1'b0;
    logic [31:0] src_val = '0;
    logic [7:0]  amt_val = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [3:0]  rd_idx;
    logic [3:0]  rs_idx;
    logic [3:0]  ra_idx;
    logic        reg_we;
    logic [31:0] result;
    logic        flag_n;
    logic        flag_z;
    logic        flag_c;
    logic        flag_we;
    logic        other_insn;
    logic        unpredictable;
    logic        no_match;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lsl_exec i_lsl_exec (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .instr         (instr),
        .is_wide       (is_wide),
        .in_cond_blk   (in_cond_blk),
        .src_val       (src_val),
        .amt_val       (amt_val),
        .carry_in      (carry_in),
        .out_valid     (out_valid),
        .rd_idx        (rd_idx),
        .rs_idx        (rs_idx),
        .ra_idx        (ra_idx),
        .reg_we        (reg_we),
        .result        (result),
        .flag_n        (flag_n),
        .flag_z        (flag_z),
        .flag_c        (flag_c),
        .flag_we       (flag_we),
        .other_insn    (other_insn),
        .unpredictable (unpredictable),
        .no_match      (no_match)
    );

    task automatic chk(input string what, input int req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        instr       = v.instr;
        is_wide     = v.wide;
        in_cond_blk = v.cb;
        src_val     = v.src;
        amt_val     = v.amt;
        carry_in    = v.cin;
        in_valid    = 1'b1;
    endtask

    task automatic check_vec(input vec_t v);
        int r;
        r = int'(v.req);
        chk("out_valid", r, {31'd0, out_valid}, 32'd1);
        case (v.kind)
            K_EXE: begin
                chk("reg_we", r, {31'd0, reg_we}, 32'd1);
                chk("rd_idx", r, {28'd0, rd_idx}, {28'd0, v.rd});
                chk("rs_idx", r, {28'd0, rs_idx}, {28'd0, v.rs});
                if (v.isreg) chk("ra_idx", r, {28'd0, ra_idx}, {28'd0, v.ra});
                chk("result", r, result, v.res);
                chk("flag_we", r, {31'd0, flag_we}, {31'd0, v.fwe});
                if (v.fwe) begin
                    chk("flag_c", r, {31'd0, flag_c}, {31'd0, v.c});
                    chk("flag_n", r, {31'd0, flag_n}, {31'd0, v.res[31]});
                    chk("flag_z", r, {31'd0, flag_z}, {31'd0, (v.res == 32'd0)});
                end
                chk("status", r, {29'd0, other_insn, unpredictable, no_match}, 32'd0);
            end
            K_OTH: begin
                chk("other_insn", r, {31'd0, other_insn}, 32'd1);
                chk("writes", r, {30'd0, reg_we, flag_we}, 32'd0);
            end
            K_UNP: begin
                chk("unpredictable", r, {31'd0, unpredictable}, 32'd1);
                chk("writes", r, {30'd0, reg_we, flag_we}, 32'd0);
            end
            default: begin
                chk("no_match", r, {31'd0, no_match}, 32'd1);
                chk("writes", r, {30'd0, reg_we, flag_we}, 32'd0);
            end
        endcase
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("reset out_valid", 12, {31'd0, out_valid}, 32'd0);
        chk("reset writes", 12, {30'd0, reg_we, flag_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("idle out_valid", 12, {31'd0, out_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check_vec(VECS[i]);
        end

        // R12 one cycle only, then idle
        @(negedge clk);
        chk("out_valid drops", 12, {31'd0, out_valid}, 32'd0);
        chk("writes drop", 12, {30'd0, reg_we, flag_we}, 32'd0);

        // R12 back-to-back strobes: each outcome on the following cycle
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        check_vec(VECS[0]);
        drive(VECS[4]);
        @(negedge clk);
        check_vec(VECS[4]);
        drive(VECS[21]);
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(VECS[21]);
        @(negedge clk);
        chk("idle after burst", 12, {31'd0, out_valid}, 32'd0);

        // R12 reset in the middle of an emit clears the outputs
        drive(VECS[0]);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("reset mid emit", 12, {29'd0, out_valid, reg_we, flag_we}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule